// File: doc/BRIEF.md
# Mixed Page-Size Translation Buffer

This block caches virtual-to-physical translations for two page sizes, 4KB and 2MB, in a single set-associative array. Each entry holds a valid bit, a two-bit page-size code, a virtual page number and a physical frame number. A lookup presents the virtual page number, which is bits [47:12] of a 48-bit virtual address. Each way compares either all 36 bits or only the upper 27 bits, depending on the size code stored in that entry. The result comes back one cycle later as a hit flag, a 40-bit frame number and the size code. For a 2MB hit, the low nine frame bits are taken from the virtual address, so the frame can be used directly in a physical cache tag compare.

A page walker outside this block writes finished translations through the fill port. The fill carries a flag that is set when the walk ended on a directory-level entry marked as a large page. A single flush input empties the whole array in one cycle. The array is 4-way, with 512 sets indexed by virtual address bits [20:12] for both page sizes. The number of sets and the number of ways are parameters.

Top module: `tlb_mixed`

## Requirements
- R1: After reset, every lookup misses.
- R2: `rsp_valid` is high exactly one cycle after each cycle in which `lkp_valid` is high. `rsp_hit` is never high while `rsp_valid` is low.
- R3: A 4KB entry (size code 2'b00) hits only when all 36 bits of `lkp_vpn` (VA[47:12]) equal its stored number. It then returns the stored 40-bit frame and size 2'b00.
- R4: A 2MB entry (size code 2'b01) hits when `lkp_vpn[35:9]` (VA[47:21]) equals its stored number. The frame returned is stored frame bits [39:9] followed by `lkp_vpn[8:0]`. The low nine bits of the filled frame have no effect on the output.
- R5: The set is chosen by `lkp_vpn[8:0]` (VA[20:12]) for both sizes. An address in the same 2MB page but in a different set misses until that set is filled too.
- R6: A miss returns `rsp_hit` low, frame zero and size 2'b00.
- R7: A fill becomes visible to lookups from the next cycle. A lookup in the same cycle as the fill sees the old contents.
- R8: A fill that matches no entry goes to the lowest-numbered invalid way of its set. When all four ways are valid, it replaces the way chosen by a per-set round-robin pointer, which starts at way 0 and advances after each such replacement.
- R9: A fill whose address already hits a valid entry in its set overwrites that same way. The other ways are left untouched.
- R10: `flush` clears every entry in one cycle. A lookup in the flush cycle misses, and a fill in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_vpn | input | 36 | Virtual address bits [47:12] to translate |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Write a walk result |
| fill_vpn | input | 36 | Virtual address bits [47:12] of the walk result |
| fill_frame | input | 40 | Frame number; for 2MB only bits [39:9] are kept in use |
| fill_huge | input | 1 | Walk ended on a large-page directory entry (2MB) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | 40 | Translated 40-bit frame number, zero on a miss |
| rsp_size | output | 2 | Page-size code of the hit entry: 2'b00 for 4KB, 2'b01 for 2MB |

## Verification
Lookups of 4KB entries are tried with addresses that differ from the stored one in a high tag bit and in an index bit, which tells a full compare from a truncated one. 2MB entries are filled with nonzero low frame bits and probed at different 4KB offsets inside the page. This separates the appended address bits from stored junk, and shows that a neighbouring set stays empty. A set is filled past its four ways and one way is then refilled, which separates round-robin replacement, invalid-first placement and overwrite on match. A fill and a lookup issued together, and a flush issued together with both, pin down ordering within a cycle.

// File: rtl/tlb_pkg.sv
// Package: shared constants and the page-size code for the mixed-size TLB.
// Assumes 48-bit virtual addresses, 4KB base pages and 2MB large pages.
package tlb_pkg;
    localparam int VA_W       = 48;
    localparam int PG_SHIFT   = 12;
    localparam int HUGE_SHIFT = 9;                // 2MB / 4KB = 2^9
    localparam int VPN_W      = VA_W - PG_SHIFT;  // 36
    localparam int FRAME_W    = 40;
    localparam int SIZE_W     = 2;

    typedef enum logic [SIZE_W-1:0] {
        PS_4K = 2'b00,
        PS_2M = 2'b01
    } pgsz_e;
endpackage

// File: rtl/tlb_way_cmp.sv
// Module: compares one stored entry against a requested page number.
// A 4KB entry compares every bit. A 2MB entry ignores the low HUGE_SHIFT
// bits, which lie inside the large page.
// Assumes the size code holds PS_4K or PS_2M; any other code never matches.
module tlb_way_cmp
    import tlb_pkg::*;
(
    input  logic             ent_valid,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             match
);
    // Purpose: masked tag compare chosen by the entry's size code.
    always_comb begin
        unique case (ent_size)
            PS_4K:   match = ent_valid && (ent_vpn == req_vpn);
            PS_2M:   match = ent_valid &&
                             (ent_vpn[VPN_W-1:HUGE_SHIFT] == req_vpn[VPN_W-1:HUGE_SHIFT]);
            default: match = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the way written by a fill within one set.
// The order of preference is a matching way, then the lowest invalid way,
// then the round-robin way. use_rr tells the caller to advance its pointer.
// Assumes rr_ptr is below WAYS.
module tlb_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  match,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way,
    output logic             use_rr
);
    logic             any_match, any_free;
    logic [WAY_W-1:0] match_way, free_way;

    // Purpose: lowest-index matching way and lowest-index free way.
    always_comb begin
        any_match = 1'b0;
        any_free  = 1'b0;
        match_way = '0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                any_match = 1'b1;
                match_way = WAY_W'(w);
            end
            if (!valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // Purpose: apply the preference order.
    always_comb begin
        use_rr = 1'b0;
        if (any_match)     way = match_way;
        else if (any_free) way = free_way;
        else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_mixed.sv
// Module: set-associative TLB holding 4KB and 2MB translations together.
// Lookup is combinational on the request and the response is registered.
// For a 2MB hit the frame is built from the stored upper bits and the
// request's low page-number bits. Flush takes priority over fill.
// Assumes the set index lies within VA[20:12] (SETS <= 512) and that
// WAYS is a power of two.
module tlb_mixed
    import tlb_pkg::*;
#(
    parameter int SETS = 512,
    parameter int WAYS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid,
    input  logic [VPN_W-1:0]   lkp_vpn,
    input  logic               flush,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_huge,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic [SIZE_W-1:0]  rsp_size
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]    valid_q [SETS];
    logic [SIZE_W-1:0]  size_q  [SETS][WAYS];
    logic [VPN_W-1:0]   vpn_q   [SETS][WAYS];
    logic [FRAME_W-1:0] frame_q [SETS][WAYS];
    logic [WAY_W-1:0]   rr_q    [SETS];

    logic [IDX_W-1:0]   lkp_set, fill_set;
    logic [WAYS-1:0]    lkp_match, fill_match;
    logic               any_hit;
    logic [WAY_W-1:0]   hit_way;
    logic [FRAME_W-1:0] sel_frame, out_frame;
    logic [SIZE_W-1:0]  sel_size;
    logic [WAY_W-1:0]   fill_way;
    logic               fill_use_rr, fill_do;
    pgsz_e              fill_size;

    assign lkp_set   = lkp_vpn[IDX_W-1:0];
    assign fill_set  = fill_vpn[IDX_W-1:0];
    assign fill_do   = fill_valid && !flush;
    assign fill_size = fill_huge ? PS_2M : PS_4K;

    // One comparator per way on the lookup side and one on the fill side.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_cmp u_lcmp (
            .ent_valid (valid_q[lkp_set][w]),
            .ent_size  (size_q[lkp_set][w]),
            .ent_vpn   (vpn_q[lkp_set][w]),
            .req_vpn   (lkp_vpn),
            .match     (lkp_match[w])
        );
        tlb_way_cmp u_fcmp (
            .ent_valid (valid_q[fill_set][w]),
            .ent_size  (size_q[fill_set][w]),
            .ent_vpn   (vpn_q[fill_set][w]),
            .req_vpn   (fill_vpn),
            .match     (fill_match[w])
        );
    end

    // Purpose: lowest-index hit way for the lookup.
    always_comb begin
        any_hit = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lkp_match[w]) begin
                any_hit = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // Purpose: read the hit way and build the 40-bit frame.
    always_comb begin
        sel_frame = frame_q[lkp_set][hit_way];
        sel_size  = size_q[lkp_set][hit_way];
        if (sel_size == PS_2M)
            out_frame = {sel_frame[FRAME_W-1:HUGE_SHIFT], lkp_vpn[HUGE_SHIFT-1:0]};
        else
            out_frame = sel_frame;
    end

    // Purpose: register the response; a miss returns zero frame and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            rsp_size  <= '0;
        end else begin
            rsp_valid <= lkp_valid;
            if (lkp_valid && any_hit && !flush) begin
                rsp_hit   <= 1'b1;
                rsp_frame <= out_frame;
                rsp_size  <= sel_size;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_frame <= '0;
                rsp_size  <= PS_4K;
            end
        end
    end

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .valid  (valid_q[fill_set]),
        .match  (fill_match),
        .rr_ptr (rr_q[fill_set]),
        .way    (fill_way),
        .use_rr (fill_use_rr)
    );

    // Purpose: write tag, size and frame of a fill (no reset needed).
    always_ff @(posedge clk) begin
        if (fill_do) begin
            vpn_q[fill_set][fill_way]   <= fill_vpn;
            size_q[fill_set][fill_way]  <= fill_size;
            frame_q[fill_set][fill_way] <= fill_frame;
        end
    end

    // Purpose: valid bits, cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_do) begin
            valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    // Purpose: per-set round-robin pointer, advanced on each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (fill_do && fill_use_rr) begin
            rr_q[fill_set] <= (rr_q[fill_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[fill_set] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_mixed_chk.sv
// Module: assertion checker for tlb_mixed, bound to every instance.
module tlb_mixed_chk
    import tlb_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lkp_valid,
    input logic [HUGE_SHIFT-1:0] lkp_low,
    input logic                  flush,
    input logic                  rsp_valid,
    input logic                  rsp_hit,
    input logic [FRAME_W-1:0]    rsp_frame,
    input logic [SIZE_W-1:0]     rsp_size
);
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);
    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_frame == '0 && rsp_size == PS_4K));
    a_r10_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lkp_valid) |=> !rsp_hit);
    a_r4_huge_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_size == PS_2M) |-> (rsp_frame[HUGE_SHIFT-1:0] == $past(lkp_low)));
    a_r3_size_known: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_size == PS_4K || rsp_size == PS_2M));
endmodule

bind tlb_mixed tlb_mixed_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_low   (lkp_vpn[tlb_pkg::HUGE_SHIFT-1:0]),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_frame (rsp_frame),
    .rsp_size  (rsp_size)
);

// File: tb/tb_tlb_mixed.sv
// Directed bench for tlb_mixed: one task per scenario, each checking itself.
module tb_tlb_mixed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [35:0] lkp_vpn = '0;
    logic        flush = 1'b0;
    logic        fill_valid = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [39:0] fill_frame = '0;
    logic        fill_huge = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [39:0] rsp_frame;
    logic [1:0]  rsp_size;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tlb_mixed dut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
        .flush(flush), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_frame(fill_frame), .fill_huge(fill_huge),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
        .rsp_size(rsp_size)
    );

    function automatic logic [35:0] mk(input logic [26:0] tag, input logic [8:0] set);
        return {tag, set};
    endfunction

    task automatic expect_rsp(input string req, input bit hit,
                              input logic [39:0] frame, input logic [1:0] size);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_frame !== frame || rsp_size !== size) begin
            n_fails++;
            $display("FAIL %s: got valid=%b hit=%b frame=%h size=%b, expected valid=1 hit=%b frame=%h size=%b",
                     req, rsp_valid, rsp_hit, rsp_frame, rsp_size, hit, frame, size);
        end
    endtask

    // Lookup: drive at a falling edge, sample after the next rising edge.
    task automatic look(input logic [35:0] v);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_vpn   = v;
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic fill(input logic [35:0] v, input logic [39:0] f, input bit huge);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = v;
        fill_frame = f;
        fill_huge  = huge;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset();
        look(mk(27'h1, 9'h0));
        expect_rsp("R1 miss after reset", 1'b0, '0, 2'b00);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R2 idle: got rsp_valid=%b expected 0", rsp_valid);
        end
    endtask

    task automatic t_small_page();
        fill(mk(27'h0ABCDE, 9'h003), 40'hAB_CDEF_0123, 1'b0);
        look(mk(27'h0ABCDE, 9'h003));
        expect_rsp("R3 4KB hit", 1'b1, 40'hAB_CDEF_0123, 2'b00);
        look(mk(27'h0ABCDE ^ 27'h200, 9'h003));
        expect_rsp("R3 4KB tag bit differs", 1'b0, '0, 2'b00);
        look(mk(27'h0ABCDE, 9'h002));
        expect_rsp("R6 4KB other set miss", 1'b0, '0, 2'b00);
    endtask

    task automatic t_large_page();
        fill(mk(27'h1234567, 9'h045), 40'h55_6677_81FF, 1'b1);
        look(mk(27'h1234567, 9'h045));
        expect_rsp("R4 2MB hit appends VA bits", 1'b1, {31'h2AB33BC0, 9'h045}, 2'b01);
        look(mk(27'h1234566, 9'h045));
        expect_rsp("R4 2MB tag differs", 1'b0, '0, 2'b00);
        look(mk(27'h1234567, 9'h046));
        expect_rsp("R5 same 2MB page other set", 1'b0, '0, 2'b00);
        fill(mk(27'h1234567, 9'h046), 40'h55_6677_8000, 1'b1);
        look(mk(27'h1234567, 9'h046));
        expect_rsp("R5 second set filled", 1'b1, {31'h2AB33BC0, 9'h046}, 2'b01);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = mk(27'h777, 9'h010);
        fill_frame = 40'h00_0000_7777; fill_huge = 1'b0;
        lkp_valid = 1'b1;  lkp_vpn = mk(27'h777, 9'h010);
        @(negedge clk);
        fill_valid = 1'b0; lkp_valid = 1'b0;
        expect_rsp("R7 lookup with fill sees old", 1'b0, '0, 2'b00);
        look(mk(27'h777, 9'h010));
        expect_rsp("R7 visible next cycle", 1'b1, 40'h00_0000_7777, 2'b00);
    endtask

    task automatic t_replace();
        for (int i = 0; i < 6; i++)
            fill(mk(27'h100 + 27'(i), 9'h155), 40'h10_0000_0000 + 40'(i), 1'b0);
        // Entries 0 and 1 replaced by 4 and 5 in round-robin order.
        look(mk(27'h100, 9'h155)); expect_rsp("R8 first victim way0", 1'b0, '0, 2'b00);
        look(mk(27'h101, 9'h155)); expect_rsp("R8 second victim way1", 1'b0, '0, 2'b00);
        for (int i = 2; i < 6; i++) begin
            look(mk(27'h100 + 27'(i), 9'h155));
            expect_rsp("R8 survivor", 1'b1, 40'h10_0000_0000 + 40'(i), 2'b00);
        end
    endtask

    task automatic t_overwrite();
        for (int i = 0; i < 4; i++)
            fill(mk(27'h200 + 27'(i), 9'h0AA), 40'h20_0000_0000 + 40'(i), 1'b0);
        fill(mk(27'h201, 9'h0AA), 40'h2F_FFFF_0001, 1'b0);
        look(mk(27'h201, 9'h0AA));
        expect_rsp("R9 refilled entry new frame", 1'b1, 40'h2F_FFFF_0001, 2'b00);
        look(mk(27'h200, 9'h0AA));
        expect_rsp("R9 way0 untouched", 1'b1, 40'h20_0000_0000, 2'b00);
        look(mk(27'h203, 9'h0AA));
        expect_rsp("R9 way3 untouched", 1'b1, 40'h20_0000_0003, 2'b00);
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        lkp_valid = 1'b1; lkp_vpn = mk(27'h0ABCDE, 9'h003);
        fill_valid = 1'b1; fill_vpn = mk(27'h999, 9'h011);
        fill_frame = 40'h99; fill_huge = 1'b0;
        @(negedge clk);
        flush = 1'b0; lkp_valid = 1'b0; fill_valid = 1'b0;
        expect_rsp("R10 lookup in flush cycle", 1'b0, '0, 2'b00);
        look(mk(27'h1234567, 9'h045));
        expect_rsp("R10 2MB entry cleared", 1'b0, '0, 2'b00);
        look(mk(27'h999, 9'h011));
        expect_rsp("R10 fill in flush dropped", 1'b0, '0, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small_page();
        t_large_page();
        t_same_cycle();
        t_replace();
        t_overwrite();
        t_flush();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule